// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the software-facing side of a serial port. A simple single-cycle bus selects a 32-bit word inside a 4 KB window. The block decodes that word index to a set of configuration registers: control, line control, integer and fractional baud divisors, the low-power divisor, FIFO level select, interrupt mask and DMA control. It also provides a read-only flag word and fixed identification bytes in the top eight words of the window.

The block does not contain the FIFOs or the serializer. A write to the data word hands a byte and a push strobe to the transmit FIFO. A read of the data word returns the byte that the receive FIFO presents and pulses a pop strobe. The receive FIFO signals each arriving byte, and also signals when it holds a single entry.

The block keeps a raw interrupt status for transmit and receive. Software clears that status through a write-one-to-clear word. The block presents the masked status as a register and as a single level interrupt line. An access to any word the block does not implement is flagged on a one-cycle error strobe.

Top module: `uart_regs_fe`

## Requirements
- R1: After reset, control reads 0x300, FIFO level select reads 0x12, and all other stored registers, the raw status and `irq` are zero.
- R2: The read/write words (0x20 low-power divisor, 8 bits; 0x24 integer divisor, 16 bits; 0x28 fractional divisor, 6 bits; 0x2C line control, 8 bits; 0x30 control, 16 bits; 0x34 level select, 6 bits; 0x38 mask, 11 bits; 0x48 DMA control, 3 bits) read back the written value truncated to their width, with the upper bits zero.
- R3: A read of offset 0x18 returns the FIFO status inputs at bit 7 (`tx_empty`), bit 6 (`rx_full`), bit 5 (`tx_full`) and bit 4 (`rx_empty`), with all other bits zero.
- R4: Reads of offsets 0xFE0 to 0xFFC return, in ascending address order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R5: A write to offset 0x00 drives `tx_push` high in that cycle, drives `tx_byte` with the low 8 bits of the write data, and sets raw status bit 5 (TX) at the clock edge.
- R6: A read of offset 0x00 returns `rx_data` zero-extended and drives `rx_pop` high in that cycle. If `rx_last` is high during the read, raw status bit 4 (RX) clears at the clock edge.
- R7: A pulse on `rx_push` sets raw bit 4. When it coincides with a clearing action on bit 4, the set takes priority.
- R8: A write to offset 0x44 clears each raw status bit whose written bit is 1 and leaves the other bits unchanged.
- R9: Offset 0x3C reads the raw status, and offset 0x40 reads raw AND mask. `irq` is high exactly when that AND is nonzero, and it follows the edge that changes raw or mask.
- R10: A read or write of an unimplemented word returns zero and changes no state. This includes writes to 0x18, 0x3C, 0x40 and the ID words, and reads of 0x44. `bus_err` is high for exactly the one cycle after each such access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_err | output | 1 | Pulse one cycle after an undecoded access |
| tx_push | output | 1 | Push `tx_byte` into the transmit FIFO |
| tx_byte | output | 8 | Byte to transmit |
| rx_pop | output | 1 | Pop the receive FIFO |
| rx_data | input | 8 | Head byte of the receive FIFO |
| rx_last | input | 1 | Receive FIFO holds one entry |
| rx_push | input | 1 | A byte entered the receive FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters. With a 12-bit offset, the identification words land at 0xFE0 and the data, flag, mask and clear words land at their fixed offsets. With the default register widths, a write of all ones exposes every truncation boundary. Random accesses draw from the whole 4 KB window, so the undecoded holes and the read-only words are hit often. Directed cases place a receive push in the same cycle as a clear, and a data read with and without `rx_last`, to reach the priority ordering on the RX bit.

// File: rtl/uart_regs_fe.sv
`timescale 1ns/1ps
module uart_regs_fe #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16,
  parameter int LCR_W  = 8,
  parameter int IBRD_W = 16,
  parameter int FBRD_W = 6,
  parameter int ILPR_W = 8,
  parameter int IFLS_W = 6,
  parameter int IRQ_W  = 11,
  parameter int DMAC_W = 3,
  parameter logic [CTRL_W-1:0] CTRL_RST = 'h300,
  parameter logic [IFLS_W-1:0] IFLS_RST = 'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  output logic              rx_pop,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_push,
  input  logic              tx_empty,
  input  logic              tx_full,
  input  logic              rx_empty,
  input  logic              rx_full,
  output logic              irq
);
  localparam int IDX_W   = ADDR_W - 2;
  localparam int ID_BASE = (1 << IDX_W) - 8;
  localparam int TX_BIT  = 5;
  localparam int RX_BIT  = 4;
  localparam logic [IDX_W-1:0] I_DATA = 0,  I_FLAG = 6,  I_ILPR = 8,  I_IBRD = 9,
                               I_FBRD = 10, I_LCR  = 11, I_CTRL = 12, I_IFLS = 13,
                               I_MASK = 14, I_RAW  = 15, I_MIS  = 16, I_ICLR = 17,
                               I_DMAC = 18;

  logic [CTRL_W-1:0] ctrl_q;
  logic [LCR_W-1:0]  lcr_q;
  logic [IBRD_W-1:0] ibrd_q;
  logic [FBRD_W-1:0] fbrd_q;
  logic [ILPR_W-1:0] ilpr_q;
  logic [IFLS_W-1:0] ifls_q;
  logic [IRQ_W-1:0]  mask_q, raw_q, raw_d, mis;
  logic [DMAC_W-1:0] dmac_q;
  logic              rd_ok, wr_ok;

  wire [IDX_W-1:0] idx  = bus_addr[ADDR_W-1:2];
  wire             wr_a = bus_sel & bus_wr;
  wire             rd_a = bus_sel & ~bus_wr;
  wire             id_win = (int'(idx) >= ID_BASE);

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h11;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  assign mis     = raw_q & mask_q;
  assign irq     = |mis;
  assign tx_push = wr_a && idx == I_DATA;
  assign tx_byte = bus_wdata[7:0];
  assign rx_pop  = rd_a && idx == I_DATA;

  always_comb begin
    bus_rdata = '0;
    rd_ok     = 1'b1;
    if (id_win) bus_rdata[7:0] = id_byte(idx[2:0]);
    else begin
      case (idx)
        I_DATA: bus_rdata[7:0] = rx_data;
        I_FLAG: bus_rdata[7:4] = {tx_empty, rx_full, tx_full, rx_empty};
        I_ILPR: bus_rdata[ILPR_W-1:0] = ilpr_q;
        I_IBRD: bus_rdata[IBRD_W-1:0] = ibrd_q;
        I_FBRD: bus_rdata[FBRD_W-1:0] = fbrd_q;
        I_LCR:  bus_rdata[LCR_W-1:0]  = lcr_q;
        I_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
        I_IFLS: bus_rdata[IFLS_W-1:0] = ifls_q;
        I_MASK: bus_rdata[IRQ_W-1:0]  = mask_q;
        I_RAW:  bus_rdata[IRQ_W-1:0]  = raw_q;
        I_MIS:  bus_rdata[IRQ_W-1:0]  = mis;
        I_DMAC: bus_rdata[DMAC_W-1:0] = dmac_q;
        default: rd_ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    case (idx)
      I_DATA, I_ILPR, I_IBRD, I_FBRD, I_LCR, I_CTRL,
      I_IFLS, I_MASK, I_ICLR, I_DMAC: wr_ok = 1'b1;
      default: wr_ok = 1'b0;
    endcase
  end

  always_comb begin
    raw_d = raw_q;
    if (tx_push) raw_d[TX_BIT] = 1'b1;
    if (wr_a && idx == I_ICLR) raw_d = raw_d & ~bus_wdata[IRQ_W-1:0];
    if (rx_pop && rx_last) raw_d[RX_BIT] = 1'b0;
    if (rx_push) raw_d[RX_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      ifls_q  <= IFLS_RST;
      lcr_q   <= '0;
      ibrd_q  <= '0;
      fbrd_q  <= '0;
      ilpr_q  <= '0;
      mask_q  <= '0;
      dmac_q  <= '0;
      raw_q   <= '0;
      bus_err <= 1'b0;
    end else begin
      raw_q   <= raw_d;
      bus_err <= bus_sel & ~(bus_wr ? wr_ok : rd_ok);
      if (wr_a) begin
        case (idx)
          I_ILPR: ilpr_q <= bus_wdata[ILPR_W-1:0];
          I_IBRD: ibrd_q <= bus_wdata[IBRD_W-1:0];
          I_FBRD: fbrd_q <= bus_wdata[FBRD_W-1:0];
          I_LCR:  lcr_q  <= bus_wdata[LCR_W-1:0];
          I_CTRL: ctrl_q <= bus_wdata[CTRL_W-1:0];
          I_IFLS: ifls_q <= bus_wdata[IFLS_W-1:0];
          I_MASK: mask_q <= bus_wdata[IRQ_W-1:0];
          I_DMAC: dmac_q <= bus_wdata[DMAC_W-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_regs_fe_chk.sv
`timescale 1ns/1ps
module uart_regs_fe_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 16,
  parameter int IRQ_W  = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_err,
  input logic              tx_push,
  input logic              rx_pop,
  input logic              rx_push,
  input logic [IRQ_W-1:0]  raw_q,
  input logic [CTRL_W-1:0] ctrl_q
);
  wire iclr_wr = bus_sel && bus_wr && bus_addr[ADDR_W-1:2] == 17;

  AST_TX_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n) tx_push |=> raw_q[5]); // R5
  AST_PUSH_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n) tx_push |-> bus_sel && bus_wr); // R5
  AST_POP_IS_READ: assert property (@(posedge clk) disable iff (!rst_n) rx_pop |-> bus_sel && !bus_wr); // R6
  AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) rx_push |=> raw_q[4]); // R7
  AST_CLR_TX: assert property (@(posedge clk) disable iff (!rst_n) iclr_wr && bus_wdata[5] |=> !raw_q[5]); // R8
  AST_CLR_RX: assert property (@(posedge clk) disable iff (!rst_n) iclr_wr && bus_wdata[4] && !rx_push |=> !raw_q[4]); // R8
  AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> $past(bus_sel)); // R10
  AST_BAD_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n) bus_err && $past(bus_wr) |-> $stable(ctrl_q)); // R10
endmodule

bind uart_regs_fe uart_regs_fe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W), .IRQ_W(IRQ_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_err(bus_err), .tx_push(tx_push), .rx_pop(rx_pop),
  .rx_push(rx_push), .raw_q(raw_q), .ctrl_q(ctrl_q));

// File: tb/uart_regs_fe_tb_top.sv
`timescale 1ns/1ps
module uart_regs_fe_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0, rx_last = 0, rx_push = 0;
  logic tx_empty = 1, tx_full = 0, rx_empty = 1, rx_full = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] rx_data = '0, tx_byte;
  logic bus_err, tx_push, rx_pop, irq;
  int checks = 0, errors = 0;
  logic [31:0] m_reg [0:31];
  logic [10:0] m_raw = '0;
  logic [3:0]  fl = 4'b1001;

  always #2.5 clk = ~clk;

  uart_regs_fe dut_i (.*);

  function automatic logic [31:0] wmask(int i);
    case (i)
      8: return 32'hFF;   9: return 32'hFFFF; 10: return 32'h3F; 11: return 32'hFF;
      12: return 32'hFFFF; 13: return 32'h3F; 14: return 32'h7FF; 18: return 32'h7;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] idb(int k);
    case (k)
      0: return 8'h11; 1: return 8'h10; 2: return 8'h14; 3: return 8'h00;
      4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int i);
    if (i >= 1016) return {24'h0, idb(i - 1016)};
    if (wmask(i) != 0) return m_reg[i];
    case (i)
      0: return {24'h0, rx_data};
      6: return {24'h0, fl, 4'h0};
      15: return {21'h0, m_raw};
      16: return {21'h0, m_raw & m_reg[14][10:0]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic acc(bit w, logic [11:0] a, logic [31:0] d, bit push, bit last, string tag);
    int i = int'(a[11:2]);
    bit bad;
    @(negedge clk);
    {tx_empty, rx_full, tx_full, rx_empty} = fl;
    rx_data = 8'($urandom); rx_last = last; rx_push = push;
    bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
    #1;
    if (!w) chk(tag, bus_rdata, exp_rd(i));
    chk("R6", {31'h0, rx_pop}, {31'h0, !w && i == 0});
    chk("R5", {31'h0, tx_push}, {31'h0, w && i == 0});
    if (w && i == 0) chk("R5", {24'h0, tx_byte}, {24'h0, d[7:0]});
    if (w) begin
      bad = !(i == 0 || i == 17 || wmask(i) != 0);
      if (wmask(i) != 0) m_reg[i] = d & wmask(i);
      if (i == 0) m_raw[5] = 1'b1;
      if (i == 17) m_raw = m_raw & ~d[10:0];
    end else begin
      bad = !(i == 0 || i == 6 || i == 15 || i == 16 || i >= 1016 || wmask(i) != 0);
      if (i == 0 && last) m_raw[4] = 1'b0;
    end
    if (push) m_raw[4] = 1'b1;
    @(negedge clk);
    bus_sel = 0; rx_push = 0;
    chk("R10", {31'h0, bus_err}, {31'h0, bad});
    chk("R9", {31'h0, irq}, {31'h0, |(m_raw & m_reg[14][10:0])});
    @(negedge clk);
    chk("R10", {31'h0, bus_err}, 32'h0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 32; k++) m_reg[k] = 32'h0;
    m_reg[12] = 32'h300; m_reg[13] = 32'h12;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", {31'h0, irq}, 32'h0);
    acc(0, 12'h030, 0, 0, 0, "R1"); acc(0, 12'h034, 0, 0, 0, "R1");
    acc(0, 12'h038, 0, 0, 0, "R1"); acc(0, 12'h03C, 0, 0, 0, "R1");
    acc(0, 12'h024, 0, 0, 0, "R1"); acc(0, 12'h018, 0, 0, 0, "R1");
    for (int k = 0; k < 8; k++) acc(0, 12'hFE0 + 12'(4 * k), 0, 0, 0, "R4");
    foreach (m_reg[k]) if (wmask(k) != 0) begin
      acc(1, 12'(4 * k), 32'hFFFF_FFFF, 0, 0, "R2");
      acc(0, 12'(4 * k), 0, 0, 0, "R2");
    end
    acc(1, 12'h038, 0, 0, 0, "R2");
    acc(1, 12'h044, 32'h7FF, 0, 0, "R8");
    for (int k = 0; k < 16; k++) begin fl = 4'(k); acc(0, 12'h018, 0, 0, 0, "R3"); end
    acc(1, 12'h000, 32'h1A5, 0, 0, "R5");
    acc(0, 12'h03C, 0, 0, 0, "R5");
    acc(1, 12'h038, 32'h20, 0, 0, "R9");
    acc(0, 12'h040, 0, 0, 0, "R9");
    acc(1, 12'h044, 32'h20, 0, 0, "R8");
    acc(0, 12'h03C, 0, 0, 0, "R8");
    acc(1, 12'h038, 32'h30, 1, 0, "R7");
    acc(0, 12'h000, 0, 0, 0, "R6");
    acc(0, 12'h03C, 0, 0, 0, "R6");
    acc(0, 12'h000, 0, 0, 1, "R6");
    acc(0, 12'h03C, 0, 0, 0, "R6");
    acc(1, 12'h044, 32'h10, 1, 0, "R7");
    acc(0, 12'h000, 0, 1, 1, "R7");
    acc(0, 12'h03C, 0, 0, 0, "R7");
    acc(1, 12'h004, 32'hFFFF, 0, 0, "R10");
    acc(0, 12'h004, 0, 0, 0, "R10");
    acc(0, 12'h044, 0, 0, 0, "R10");
    acc(1, 12'h018, 32'hFF, 0, 0, "R10");
    acc(1, 12'h03C, 32'h7FF, 0, 0, "R10");
    acc(1, 12'hFE0, 32'hFF, 0, 0, "R10");
    acc(0, 12'h03C, 0, 0, 0, "R10");
    acc(0, 12'h030, 0, 0, 0, "R10");
    for (int n = 0; n < 1500; n++) begin
      logic [11:0] a;
      int sel = int'($urandom % 5);
      fl = 4'($urandom);
      case (sel)
        0: a = 12'($urandom) & 12'hFFC;
        1: a = 12'hFE0 | (12'($urandom) & 12'h1F);
        2: a = 12'h000;
        3: a = 12'h044;
        default: a = 12'($urandom % 19) << 2;
      endcase
      acc(bit'($urandom), a, $urandom, ($urandom % 4) == 0, bit'($urandom), "R2");
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule